// File: doc/BRIEF.md
# Byte-wide ADC readout controller

This block sits on the host side of a 16-bit sampling converter whose result leaves through an 8-bit parallel port. When `start_i` is seen in the idle state, the controller selects the converter and holds the read/convert line low for a set number of cycles. This starts a conversion. It then waits for the converter's busy line to rise, which marks a new result in the output registers. The result is fetched as two bytes: the byte-select line is low for the upper byte and high for the lower byte. The two bytes are joined into one word and reported with a one-cycle strobe.

A host can also ask for the previous result while the new conversion is still running. That word can only be taken inside a fixed number of cycles after the conversion starts. The fetch is dropped if the window has already closed, or if busy rises before the fetch completes. The power-up contents of the converter are undefined, so no such early fetch is made until one conversion has been read in full. If busy never rises, a timeout sets an error flag and the controller returns to idle. The mode pins of the converter are driven to constant levels so that it uses its parallel port.

States: `ST_IDLE` (deselected), `ST_CONV` (start pulse), `ST_PREV_HI` / `ST_PREV_LO` (early fetch of the prior word), `ST_WAIT` (busy wait with timeout), `ST_READ_HI` / `ST_READ_LO` (fetch of the new word). The transitions are:
- IDLE→CONV on start.
- CONV→READ_HI if busy already rose; otherwise CONV→PREV_HI if a prior word is asked for and exists; otherwise CONV→WAIT.
- PREV_HI→PREV_LO on a sample inside the window.
- PREV_*→WAIT when the window is closed at the sample point.
- PREV_*→READ_HI when busy rises.
- PREV_LO→WAIT after its sample.
- WAIT→READ_HI on busy.
- WAIT→IDLE on timeout.
- READ_HI→READ_LO after its sample.
- READ_LO→IDLE after its sample.

Top module: `adc_byte_reader`

## Requirements
- R1: The data bus is sampled only in a cycle where `cs_n_o` is 0 and `rc_o` is 1.
- R2: On an accepted start, `cs_n_o` is 0 and `rc_o` is 0 for exactly PULSE_CYC cycles, and then `rc_o` returns to 1.
- R3: `byte_sel_o` is 0 while the upper byte is fetched, and that byte becomes `word_o[15:8]`. `byte_sel_o` is 1 while the lower byte is fetched, and that byte becomes `word_o[7:0]`. `byte_sel_o` is 0 in idle.
- R4: Each byte is sampled only after SETTLE_CYC full cycles in which `cs_n_o`, `rc_o` and `byte_sel_o` have held their values.
- R5: After busy rises (seen through a SYNC_STAGES-flop synchronizer), the new word is fetched and `valid_o` pulses for one cycle with `prev_flag_o` = 0.
- R6: If `prev_i` is 1 when a start is accepted and a full current word has already been read since reset, the prior word is reported first with `prev_flag_o` = 1. With no such word, nothing is reported with `prev_flag_o` = 1.
- R7: An early fetch byte is sampled only while fewer than WINDOW_CYC cycles have passed since the start was accepted. Otherwise the early fetch is dropped with no word reported, and the new word is still read.
- R8: If busy rises before the early fetch completes, the early fetch is dropped with no word reported, and the new word is read.
- R9: If busy does not rise within TIMEOUT_CYC cycles in the wait state, `err_o` goes to 1 and the controller returns to idle (`cs_n_o` = 1, `rc_o` = 1) with no word reported. `err_o` clears when the next start is accepted.
- R10: `ext_int_o` is always 1 and `dclk_o` is always 0.
- R11: Reset leaves `cs_n_o` = 1, `rc_o` = 1, `valid_o` = 0 and `err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken in idle only |
| prev_i | input | 1 | Also fetch the prior word during this conversion |
| cs_n_o | output | 1 | Converter select, active low |
| rc_o | output | 1 | Read/convert: 0 starts a conversion, 1 enables reads |
| byte_sel_o | output | 1 | 0 selects upper byte, 1 selects lower byte |
| ext_int_o | output | 1 | Mode pin, held at 1 |
| dclk_o | output | 1 | Serial clock pin, held at 0 |
| busy_i | input | 1 | Converter busy line; a rise marks a new result |
| data_i | input | 8 | Converter data bus |
| word_o | output | 16 | Assembled word |
| valid_o | output | 1 | One-cycle strobe for `word_o` |
| prev_flag_o | output | 1 | 1 when `word_o` is the prior conversion's result |
| err_o | output | 1 | Busy timeout flag |

## Verification
The bound checker covers several rules on every cycle:
- The read/convert line is never low with the converter deselected, and the start pulse has the exact length.
- Every strobe follows a sample taken with the bus enabled and the lower byte selected, and lasts one cycle.
- No prior-result word appears before a current word exists or outside the window.
- A timeout always leaves the lines idle.

Only the bench's converter model can show that the right bytes land in the right halves. It corrupts the bus during the access time after any select change, past the window, and at power-up. The bench scenarios also show that a busy rise during an early fetch drops that fetch, and that the error flag clears on the next start.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_PREV_HI,
        ST_PREV_LO,
        ST_WAIT,
        ST_READ_HI,
        ST_READ_LO
    } rd_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_window.sv
module adc_rd_window #(
    parameter int unsigned LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic open_o
);

    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= CW'(LIMIT);
        end else if (clear_i) begin
            age_q <= '0;
        end else if (age_q < CW'(LIMIT)) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign open_o = (age_q < CW'(LIMIT));

endmodule

// File: rtl/adc_rd_assembler.sv
module adc_rd_assembler (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_hi_i,
    input  logic        cap_lo_i,
    input  logic        is_prev_i,
    input  logic [7:0]  data_i,
    output logic [15:0] word_o,
    output logic        valid_o,
    output logic        prev_o
);

    logic [7:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
            prev_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (cap_hi_i) begin
                hi_q <= data_i;
            end
            if (cap_lo_i) begin
                word_o  <= {hi_q, data_i};
                valid_o <= 1'b1;
                prev_o  <= is_prev_i;
            end
        end
    end

endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned PULSE_CYC   = 3,
    parameter int unsigned SETTLE_CYC  = 2,
    parameter int unsigned WINDOW_CYC  = 12,
    parameter int unsigned TIMEOUT_CYC = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        prev_i,
    output logic        cs_n_o,
    output logic        rc_o,
    output logic        byte_sel_o,
    output logic        ext_int_o,
    output logic        dclk_o,
    input  logic        busy_i,
    input  logic [7:0]  data_i,
    output logic [15:0] word_o,
    output logic        valid_o,
    output logic        prev_flag_o,
    output logic        err_o
);

    localparam int unsigned LOAD_MAX = max3(PULSE_CYC, SETTLE_CYC + 1, TIMEOUT_CYC);
    localparam int unsigned TW       = $clog2(LOAD_MAX + 1);

    rd_state_e      state_q, state_n;
    logic [TW-1:0]  load_val;
    logic           t_zero, win_open;
    logic           accept, cap_hi, cap_lo, timeout_hit;
    logic           prev_q, have_q, done_q, err_q;
    logic           busy_s, busy_q, busy_rise, done_any;
    logic [SYNC_STAGES-1:0] sync_q;

    // busy synchronizer
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b1;
                else        sync_q[0] <= busy_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign busy_s    = sync_q[SYNC_STAGES-1];
    assign busy_rise = busy_s & ~busy_q;
    assign done_any  = done_q | busy_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state and sample strobes
    always_comb begin
        state_n     = state_q;
        accept      = 1'b0;
        cap_hi      = 1'b0;
        cap_lo      = 1'b0;
        timeout_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    state_n = ST_CONV;
                end
            end
            ST_CONV: begin
                if (t_zero) begin
                    if (done_any)              state_n = ST_READ_HI;
                    else if (prev_q && have_q) state_n = ST_PREV_HI;
                    else                       state_n = ST_WAIT;
                end
            end
            ST_PREV_HI: begin
                if (done_any) begin
                    state_n = ST_READ_HI;
                end else if (t_zero) begin
                    if (win_open) begin
                        cap_hi  = 1'b1;
                        state_n = ST_PREV_LO;
                    end else begin
                        state_n = ST_WAIT;
                    end
                end
            end
            ST_PREV_LO: begin
                if (done_any) begin
                    state_n = ST_READ_HI;
                end else if (t_zero) begin
                    cap_lo  = win_open;
                    state_n = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (done_any) begin
                    state_n = ST_READ_HI;
                end else if (t_zero) begin
                    timeout_hit = 1'b1;
                    state_n     = ST_IDLE;
                end
            end
            ST_READ_HI: begin
                if (t_zero) begin
                    cap_hi  = 1'b1;
                    state_n = ST_READ_LO;
                end
            end
            ST_READ_LO: begin
                if (t_zero) begin
                    cap_lo  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // reload value for the state being entered
    always_comb begin
        unique case (state_n)
            ST_IDLE: load_val = '0;
            ST_CONV: load_val = TW'(PULSE_CYC - 1);
            ST_WAIT: load_val = TW'(TIMEOUT_CYC - 1);
            default: load_val = TW'(SETTLE_CYC);
        endcase
    end

    // converter control lines
    always_comb begin
        cs_n_o     = 1'b1;
        rc_o       = 1'b1;
        byte_sel_o = 1'b0;
        unique case (state_q)
            ST_CONV: begin
                cs_n_o = 1'b0;
                rc_o   = 1'b0;
            end
            ST_PREV_HI, ST_READ_HI: cs_n_o = 1'b0;
            ST_PREV_LO, ST_READ_LO: begin
                cs_n_o     = 1'b0;
                byte_sel_o = 1'b1;
            end
            default: ;
        endcase
    end

    // control flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            prev_q <= 1'b0;
            have_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            busy_q <= busy_s;
            if (accept) begin
                prev_q <= prev_i;
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end else begin
                if (busy_rise && state_q != ST_IDLE) done_q <= 1'b1;
                if (timeout_hit)                     err_q  <= 1'b1;
            end
            if (cap_lo && state_q == ST_READ_LO) have_q <= 1'b1;
        end
    end

    assign err_o     = err_q;
    assign ext_int_o = 1'b1;
    assign dclk_o    = 1'b0;

    adc_rd_timer #(.W(TW)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_n != state_q),
        .val_i  (load_val),
        .zero_o (t_zero)
    );

    adc_rd_window #(.LIMIT(WINDOW_CYC)) window_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .open_o  (win_open)
    );

    adc_rd_assembler asm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_hi_i  (cap_hi),
        .cap_lo_i  (cap_lo),
        .is_prev_i (state_q == ST_PREV_LO),
        .data_i    (data_i),
        .word_o    (word_o),
        .valid_o   (valid_o),
        .prev_o    (prev_flag_o)
    );

endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk #(
    parameter int unsigned PULSE_CYC  = 3,
    parameter int unsigned WINDOW_CYC = 12
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic rc_o,
    input logic byte_sel_o,
    input logic valid_o,
    input logic prev_flag_o,
    input logic err_o
);

    logic [15:0] low_run, since_conv;
    logic        rc_q, seen_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run    <= '0;
            since_conv <= 16'hFFFF;
            rc_q       <= 1'b1;
            seen_cur   <= 1'b0;
        end else begin
            rc_q     <= rc_o;
            low_run  <= rc_o ? 16'd0 : low_run + 16'd1;
            if (!rc_o && rc_q)              since_conv <= 16'd1;
            else if (since_conv != 16'hFFFF) since_conv <= since_conv + 16'd1;
            if (valid_o && !prev_flag_o)    seen_cur <= 1'b1;
        end
    end

    p_conv_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_o |-> !cs_n_o);

    p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_o) |-> (low_run == 16'(PULSE_CYC)));

    p_sample_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(!cs_n_o && rc_o && byte_sel_o));

    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_prev_after_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && prev_flag_o) |-> seen_cur);

    p_prev_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && prev_flag_o) |-> (since_conv <= 16'(WINDOW_CYC)));

    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (cs_n_o && rc_o && !valid_o));

endmodule

bind adc_byte_reader adc_byte_reader_chk #(
    .PULSE_CYC  (PULSE_CYC),
    .WINDOW_CYC (WINDOW_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_o      (cs_n_o),
    .rc_o        (rc_o),
    .byte_sel_o  (byte_sel_o),
    .valid_o     (valid_o),
    .prev_flag_o (prev_flag_o),
    .err_o       (err_o)
);

// File: tb/adc_byte_reader_tb_top.sv
`timescale 1ns/1ps

module adc_conv_model #(
    parameter int unsigned WIN = 14,
    parameter int unsigned ACC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rc,
    input  logic        bsel,
    input  logic        respond,
    input  logic [7:0]  lat,
    input  logic [15:0] next_val,
    output logic        busy,
    output logic [7:0]  data
);

    logic [2:0]  sel_q;
    logic [7:0]  acc_cnt, ccnt, byte_v;
    logic [15:0] out_q;
    logic        converting, stale;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= 3'b101;
            acc_cnt    <= 8'(ACC);
            converting <= 1'b0;
            ccnt       <= '0;
            out_q      <= 16'hDEAD;
            busy       <= 1'b1;
        end else begin
            sel_q <= {cs_n, bsel, rc};
            if (sel_q != {cs_n, bsel, rc})  acc_cnt <= '0;
            else if (acc_cnt < 8'(ACC))     acc_cnt <= acc_cnt + 8'd1;
            if (!converting) begin
                if (!rc && !cs_n) begin
                    converting <= 1'b1;
                    ccnt       <= '0;
                    busy       <= 1'b0;
                end
            end else begin
                if (ccnt != 8'hFF) ccnt <= ccnt + 8'd1;
                if (respond && ccnt >= lat) begin
                    out_q      <= next_val;
                    busy       <= 1'b1;
                    converting <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        byte_v = bsel ? out_q[7:0] : out_q[15:8];
        stale  = (sel_q != {cs_n, bsel, rc}) || (acc_cnt < 8'(ACC - 1)) ||
                 (converting && ccnt >= 8'(WIN));
        data   = (!cs_n && rc) ? (stale ? ~byte_v : byte_v) : 8'hA5;
    end

endmodule

module adc_byte_reader_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // main instance
    logic        start_a = 0, prev_a = 0, resp_a = 1;
    logic [7:0]  lat_a = 8'd20;
    logic [15:0] nv_a = '0;
    logic        cs_a, rc_a, bs_a, ei_a, dc_a, busy_a, val_a, pf_a, err_a;
    logic [7:0]  d_a;
    logic [15:0] w_a;

    // narrow-window instance
    logic        start_b = 0, prev_b = 0;
    logic [15:0] nv_b = '0;
    logic        cs_b, rc_b, bs_b, ei_b, dc_b, busy_b, val_b, pf_b, err_b;
    logic [7:0]  d_b;
    logic [15:0] w_b;

    adc_byte_reader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_a), .prev_i(prev_a),
        .cs_n_o(cs_a), .rc_o(rc_a), .byte_sel_o(bs_a), .ext_int_o(ei_a), .dclk_o(dc_a),
        .busy_i(busy_a), .data_i(d_a), .word_o(w_a), .valid_o(val_a),
        .prev_flag_o(pf_a), .err_o(err_a)
    );

    adc_conv_model model_a (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_a), .rc(rc_a), .bsel(bs_a), .respond(resp_a),
        .lat(lat_a), .next_val(nv_a), .busy(busy_a), .data(d_a)
    );

    adc_byte_reader #(.WINDOW_CYC(4)) dut_w (
        .clk(clk), .rst_n(rst_n), .start_i(start_b), .prev_i(prev_b),
        .cs_n_o(cs_b), .rc_o(rc_b), .byte_sel_o(bs_b), .ext_int_o(ei_b), .dclk_o(dc_b),
        .busy_i(busy_b), .data_i(d_b), .word_o(w_b), .valid_o(val_b),
        .prev_flag_o(pf_b), .err_o(err_b)
    );

    adc_conv_model model_b (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_b), .rc(rc_b), .bsel(bs_b), .respond(1'b1),
        .lat(8'd20), .next_val(nv_b), .busy(busy_b), .data(d_b)
    );

    logic [16:0] exp_a[$];
    logic [16:0] exp_b[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitors
    int rc_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (val_a) begin
                if (exp_a.size() == 0) begin
                    check(0, "R5 R6 R8 unexpected word", {15'd0, pf_a, w_a}, 32'd0);
                end else begin
                    logic [16:0] e;
                    e = exp_a.pop_front();
                    check({pf_a, w_a} == e, "R1 R3 R4 R5 R6 word", {15'd0, pf_a, w_a}, {15'd0, e});
                end
            end
            if (val_b) begin
                if (exp_b.size() == 0) begin
                    check(0, "R7 unexpected word", {15'd0, pf_b, w_b}, 32'd0);
                end else begin
                    logic [16:0] e;
                    e = exp_b.pop_front();
                    check({pf_b, w_b} == e, "R7 word", {15'd0, pf_b, w_b}, {15'd0, e});
                end
            end
            if (!rc_a) begin
                rc_run++;
            end else begin
                if (rc_run != 0) check(rc_run == 3, "R2 pulse length", rc_run, 3);
                rc_run = 0;
            end
        end
    end

    task automatic run_a(input bit pr, input logic [15:0] val, input bit want_prev,
                         input logic [15:0] old);
        int n = 0;
        if (want_prev) exp_a.push_back({1'b1, old});
        exp_a.push_back({1'b0, val});
        nv_a = val;
        prev_a = pr;
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        while (exp_a.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) check(0, "R5 word missing", exp_a.size(), 0);
        repeat (8) @(negedge clk);
    endtask

    task automatic run_b(input bit pr, input logic [15:0] val);
        int n = 0;
        exp_b.push_back({1'b0, val});
        nv_b = val;
        prev_b = pr;
        start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
        while (exp_b.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) check(0, "R7 word missing", exp_b.size(), 0);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(cs_a == 1'b1, "R11 cs_n after reset", cs_a, 1);
        check(rc_a == 1'b1, "R11 rc after reset", rc_a, 1);
        check(val_a == 1'b0, "R11 valid after reset", val_a, 0);
        check(err_a == 1'b0, "R11 err after reset", err_a, 0);
        check(bs_a == 1'b0, "R3 byte_sel idle", bs_a, 0);
        check(ei_a == 1'b1, "R10 ext_int level", ei_a, 1);
        check(dc_a == 1'b0, "R10 dclk level", dc_a, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6: prior word asked for before any result: none reported
        run_a(1'b1, 16'h1234, 1'b0, 16'h0000);
        // R5 plain conversion
        run_a(1'b0, 16'hBEEF, 1'b0, 16'h0000);
        // R6 prior word then new word
        run_a(1'b1, 16'h0F81, 1'b1, 16'hBEEF);
        // R8 busy rises early: early fetch dropped
        lat_a = 8'd1;
        run_a(1'b1, 16'h7E42, 1'b0, 16'h0000);
        lat_a = 8'd20;
        check(bs_a == 1'b0 && cs_a == 1'b1, "R3 idle after read", {bs_a, cs_a}, 2'b01);
        check(ei_a == 1'b1 && dc_a == 1'b0, "R10 mode pins after reads", {ei_a, dc_a}, 2'b10);

        // R7 narrow window: early fetch dropped
        run_b(1'b0, 16'h3C96);
        run_b(1'b1, 16'h6B21);

        // R9 timeout
        resp_a = 1'b0;
        prev_a = 1'b0;
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        repeat (120) @(negedge clk);
        check(err_a == 1'b1, "R9 timeout flag", err_a, 1);
        check(cs_a == 1'b1 && rc_a == 1'b1, "R9 idle after timeout", {cs_a, rc_a}, 2'b11);
        check(exp_a.size() == 0, "R9 no word on timeout", exp_a.size(), 0);
        start_a = 1'b1;
        @(negedge clk);
        start_a = 1'b0;
        check(err_a == 1'b0, "R9 flag cleared by start", err_a, 0);
        repeat (4) @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule